// File: doc/BRIEF.md
# If-Then Block Condition Sequencer

This block sits in an instruction decode stage and follows one conditional run that an If-Then instruction opens. When decode presents such an instruction, the block stores its 4-bit base condition and its 4-bit then/else mask. The next one to four instructions are then predicated. For each of them the block gives the condition code that execute must test. A "then" slot uses the base condition. An "else" slot uses the base condition with bit 0 flipped, so EQ becomes NE.

Decode pulses `issue` once for each instruction that leaves the stage. Each pulse uses up one slot, whether the instruction is 16 or 32 bits long. The block shows whether a run is active and whether the current slot is the final one. It flags an If-Then instruction that it cannot accept. A flush clears the run. Flag evaluation and execution are outside this block.

Top module: `itblk_seq`

## Requirements
- R1: When `it_valid` is high while no run is active, `it_mask` is non-zero and `flush` is low, then in the next cycle `in_block` is 1 and `cur_cond` equals the `it_cond` that was presented.
- R2: The run lasts a number of issued instructions set by the lowest set bit of `it_mask`. Bit 3 gives 1 slot, bit 2 gives 2, bit 1 gives 3 and bit 0 gives 4. `in_block` falls in the cycle after the final slot is issued.
- R3: Slot k (k = 1..3) of a run tests `{it_cond[3:1], it_mask[4-k]}`. A mask bit equal to `it_cond[0]` means "then" and a differing bit means "else". Bits 3:1 of the condition never change within a run. For example, base 0000 with mask 1011 gives 0000, 0001, 0000, 0001.
- R4: The run advances by exactly one slot per cycle in which `issue` is high. With `issue` low the slot and its condition hold.
- R5: `last_slot` is high exactly when the current slot is the final slot of an active run.
- R6: With no run active, `in_block` and `last_slot` are 0 and `cur_cond` shows 1110 (always).
- R7: If `it_valid` is high while a run is active, `it_illegal` is high in that cycle and the new condition and mask are discarded. An `issue` in the same cycle still advances the current run.
- R8: If `it_valid` is high with `it_mask` equal to 0000, `it_illegal` is high in that cycle and no run starts.
- R9: `flush` ends any run by the next cycle and takes priority over a load or an advance in the same cycle.
- R10: While `rst_n` is low, and directly after it rises, the block is idle as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Pipeline flush, clears the run |
| it_valid | input | 1 | An If-Then instruction is being decoded |
| it_cond | input | 4 | Base condition code of that instruction |
| it_mask | input | 4 | Then/else mask with terminating 1 bit |
| issue | input | 1 | One instruction leaves decode this cycle |
| in_block | output | 1 | A predicated run is active |
| cur_cond | output | 4 | Condition for the current instruction |
| last_slot | output | 1 | Current instruction is the run's final one |
| it_illegal | output | 1 | The presented If-Then instruction is rejected |

## Verification
The interesting collision is an If-Then instruction that arrives in the same cycle as an `issue` inside an active run. The block must reject the new payload and still take the step. The hardest case puts this on the final slot, where the run ends but the rejected instruction must not start a fresh one. The bench provokes this on purpose and also in random traffic. A queue model predicts `it_illegal`, the next condition and the idle state one cycle later, and the bench compares them with the design. It also checks a flush that coincides with a load or with an issue.

// File: rtl/itblk_seq.sv
module itblk_seq #(
  parameter logic [3:0] IDLE_COND = 4'b1110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       it_valid,
  input  logic [3:0] it_cond,
  input  logic [3:0] it_mask,
  input  logic       issue,
  output logic       in_block,
  output logic [3:0] cur_cond,
  output logic       last_slot,
  output logic       it_illegal
);

  // st[4] holds bit 0 of the current condition, st[3:0] the remaining mask
  logic [2:0] cond_hi;
  logic [4:0] st;
  logic       start;

  assign in_block   = |st[3:0];
  assign last_slot  = (st[3:0] == 4'b1000);
  assign cur_cond   = in_block ? {cond_hi, st[4]} : IDLE_COND;
  assign it_illegal = it_valid & (in_block | ~|it_mask);
  assign start      = it_valid & ~in_block & |it_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_hi <= 3'b000;
      st      <= 5'b00000;
    end else if (flush) begin
      st <= 5'b00000;
    end else if (start) begin
      cond_hi <= it_cond[3:1];
      st      <= {it_cond[0], it_mask};
    end else if (in_block && issue) begin
      st <= last_slot ? 5'b00000 : {st[3:0], 1'b0};
    end
  end

endmodule

module itblk_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flush,
  input logic       it_valid,
  input logic [3:0] it_cond,
  input logic [3:0] it_mask,
  input logic       issue,
  input logic       in_block,
  input logic [3:0] cur_cond,
  input logic       last_slot,
  input logic       it_illegal
);

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_block && it_valid && it_mask != 4'b0000 && !flush) |=> (in_block && cur_cond == $past(it_cond))); // R1

  AST_HIGH_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_block && issue && !last_slot && !flush) |=> (in_block && cur_cond[3:1] == $past(cur_cond[3:1]))); // R3

  AST_HOLD_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_block && !issue && !flush) |=> ($stable(cur_cond) && $stable(last_slot) && in_block)); // R4

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (last_slot && issue && !flush) |=> !in_block); // R5

  AST_LAST_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    last_slot |-> in_block); // R5

  AST_IDLE_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_block |-> (cur_cond == 4'b1110 && !last_slot)); // R6

  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_block && it_valid) |-> it_illegal); // R7

  AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_block && it_valid && it_mask == 4'b0000) |=> !in_block); // R8

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !in_block); // R9

endmodule

bind itblk_seq itblk_seq_chk u_itblk_seq_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .it_valid(it_valid),
  .it_cond(it_cond), .it_mask(it_mask), .issue(issue),
  .in_block(in_block), .cur_cond(cur_cond), .last_slot(last_slot),
  .it_illegal(it_illegal)
);

// File: tb/itblk_seq_bench.sv
module itblk_seq_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0;
  logic       it_valid = 1'b0;
  logic [3:0] it_cond = 4'h0;
  logic [3:0] it_mask = 4'h0;
  logic       issue = 1'b0;
  logic       in_block;
  logic [3:0] cur_cond;
  logic       last_slot;
  logic       it_illegal;

  int checks = 0;
  int fails = 0;
  string req = "R1";
  logic [3:0] q[$];

  always #5 clk = ~clk;

  itblk_seq u_itblk_seq (
    .clk(clk), .rst_n(rst_n), .flush(flush), .it_valid(it_valid),
    .it_cond(it_cond), .it_mask(it_mask), .issue(issue),
    .in_block(in_block), .cur_cond(cur_cond), .last_slot(last_slot),
    .it_illegal(it_illegal)
  );

  task automatic check(input string r, input string what, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", r, what, act, exp, $time);
    end
  endtask

  // compare outputs against the queue model before the edge
  task automatic compare(input logic v, input logic [3:0] m);
    logic busy;
    busy = q.size() > 0;
    check(req, "in_block", {3'b0, in_block}, {3'b0, busy});
    check(req, "cur_cond", cur_cond, busy ? q[0] : 4'b1110);
    check(req, "last_slot", {3'b0, last_slot}, {3'b0, q.size() == 1});
    check(req, "it_illegal", {3'b0, it_illegal}, {3'b0, v && (busy || m == 4'b0000)});
  endtask

  task automatic step(input logic v, input logic [3:0] c, input logic [3:0] m, input logic iss, input logic fl);
    logic busy;
    int low;
    it_valid = v; it_cond = c; it_mask = m; issue = iss; flush = fl;
    #2;
    compare(v, m);
    @(posedge clk);
    busy = q.size() > 0;
    if (fl) q.delete();
    else if (busy && iss) void'(q.pop_front());
    else if (!busy && v && m != 4'b0000) begin
      low = 0;
      for (int b = 3; b >= 0; b--) if (m[b]) low = b;
      q.push_back(c);
      for (int k = 3; k > low; k--) q.push_back({c[3:1], m[k]});
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    // R10 reset state
    repeat (3) @(negedge clk);
    req = "R10";
    check("R10", "in_block in reset", {3'b0, in_block}, 4'h0);
    check("R10", "cur_cond in reset", cur_cond, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", "last_slot after reset", {3'b0, last_slot}, 4'h0);

    // R1 R3 example: EQ with then,else,then,else
    req = "R3";
    step(1, 4'b0000, 4'b1011, 0, 0);
    check("R1", "loaded cond", cur_cond, 4'b0000);
    step(0, 0, 0, 1, 0); check("R3", "slot1", cur_cond, 4'b0001);
    step(0, 0, 0, 0, 0); check("R4", "hold", cur_cond, 4'b0001);
    step(0, 0, 0, 1, 0); check("R3", "slot2", cur_cond, 4'b0000);
    step(0, 0, 0, 1, 0); check("R5", "last slot", {3'b0, last_slot}, 4'h1);
    step(0, 0, 0, 1, 0); check("R6", "idle after run", cur_cond, 4'b1110);

    // R2 run length for each terminator position
    req = "R2";
    for (int b = 3; b >= 0; b--) begin
      step(1, 4'b1011, 4'b0001 << b, 0, 0);
      n = 0;
      while (in_block && n < 8) begin step(0, 0, 0, 1, 0); n++; end
      check("R2", "run length", n[3:0], 4'(4 - b));
    end

    // R7 rejected load coinciding with issue, including on the final slot
    req = "R7";
    step(1, 4'b1100, 4'b0100, 0, 0);
    step(1, 4'b0010, 4'b1111, 1, 0);
    check("R7", "advanced past reject", {3'b0, last_slot}, 4'h1);
    step(1, 4'b0010, 4'b1000, 1, 0);
    check("R7", "no start after reject", {3'b0, in_block}, 4'h0);

    // R8 zero mask
    req = "R8";
    step(1, 4'b0101, 4'b0000, 0, 0);
    check("R8", "zero mask idle", {3'b0, in_block}, 4'h0);

    // R9 flush against load and against issue
    req = "R9";
    step(1, 4'b0110, 4'b0001, 0, 1);
    check("R9", "flush beats load", {3'b0, in_block}, 4'h0);
    step(1, 4'b0110, 4'b0001, 0, 0);
    step(0, 0, 0, 1, 1);
    check("R9", "flush ends run", {3'b0, in_block}, 4'h0);

    // mixed traffic for R1..R9
    req = "R4";
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 4) == 0, 4'($urandom), 4'($urandom), ($urandom % 3) != 0, ($urandom % 40) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule